// File: doc/BRIEF.md
# Selectable-Source Reference Clock Divider

This block builds a reference clock from one of three clock sources: a crystal input and two PLL outputs. Each source reaches the block as a one-cycle tick train in the system clock domain. A single 32-bit control word picks the source and sets two ratios. The first is a prescaler that runs only when a PLL source is chosen. The second is a main divide ratio of N+1. The output comes in two forms: a one-cycle pulse per divided period, and a level that is high for roughly the first half of each period. The same word also holds an 8-bit ratio for a second channel. That channel divides its own source tick train to make the engine clock for a storage host controller.

Settings take effect only at a period boundary. A write changes the stored word at once. The main divider keeps running on its active copy of select, prescale and N until the current output period completes. It then reloads that copy and restarts its counters from zero. The engine channel changes over the same way. One select code turns the output off: pulse and level are held low, and the divider reloads on every cycle while it is off, so a new setting applies in the cycle after it is written.

Each divider is a two-state machine. RUN_TO_RUN happens at a period end when the next setting is active. RUN_TO_GATED happens at a period end when the next setting is the off code. GATED_TO_GATED happens on every cycle while the off code stays selected. GATED_TO_RUN happens on the first cycle after a usable code is written. Reset enters RUN with all ratios at zero.

Top module: `refclk_divider_top`

## Requirements
- R1: The main divide field N is bits [31:24]. The active main divider emits one `ref_pulse` for every N+1 ticks of its selected, prescaled source. N=0 passes every source tick through.
- R2: The source select is bits [20:19]. 00 selects `xtal_tick`, 10 selects `plla_tick` and 11 selects `pllu_tick`.
- R3: The prescale field S is bits [18:16]. With select 10 or 11, the chosen PLL ticks are divided by S+1 before the main divider. With select 00, S has no effect.
- R4: Select code 01 holds `ref_pulse` and `ref_clk` low. A later write of a usable code restarts the output with the new ratio.
- R5: The control word is read and written at byte offset 0x044. Only bits [31:8] except [23:21] are stored. All other bits read as zero. Reads at any other offset return zero, and writes to other offsets leave the word unchanged.
- R6: After reset the word reads 0x0000_0000 and the main output follows the crystal with divide by 1.
- R7: A new main setting takes effect only when the current output period ends, so the period in progress keeps its full old length. Counters restart from zero at the changeover.
- R8: The engine field M is bits [15:8]. `eng_pulse` fires once per M+1 ticks of `eng_src_tick`, with the same period-end changeover as R7.
- R9: `ref_clk` is high while fewer than ceil((N+1)/2) main ticks of the current period have been counted, and low for the rest of the period.
- R10: `ref_pulse` and `eng_pulse` last one cycle. Each follows, by one clock, the tick that completes its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xtal_tick | input | 1 | Crystal source tick train |
| plla_tick | input | 1 | PLL A source tick train |
| pllu_tick | input | 1 | PLL U source tick train |
| eng_src_tick | input | 1 | Engine channel source tick train |
| ref_pulse | output | 1 | One-cycle pulse per main output period |
| ref_clk | output | 1 | Near 50% duty main output level |
| eng_pulse | output | 1 | One-cycle pulse per engine period |
| eng_clk | output | 1 | Near 50% duty engine output level |

## Verification
The changeover that is hardest to reach from the ports is a write that lands in the middle of an output period. From the ports, a mistimed reload looks just like a correct one unless the interval containing the write is measured. The stimulus first locks onto an output pulse while a long ratio is active. A few cycles later it writes a short ratio. It then timestamps the next two pulses: the first interval must still be the old full length, and only the second may be the new length. The off code and its release are reached the same way, by waiting out the old period before checking that the outputs stay silent.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    // Field widths and positions inside the control word
    localparam int N_W      = 8;
    localparam int SEL_W    = 2;
    localparam int SDIV_W   = 3;
    localparam int ENG_W    = 8;
    localparam int N_LSB    = 24;
    localparam int SEL_LSB  = 19;
    localparam int SDIV_LSB = 16;
    localparam int ENG_LSB  = 8;
    localparam int CTRL_W   = 32;

    // Bits that hold storage; every other bit reads as zero
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'hFF1F_FF00;

    typedef enum logic [SEL_W-1:0] {
        SRC_XTAL  = 2'b00,
        SRC_OFF   = 2'b01,
        SRC_PLL_A = 2'b10,
        SRC_PLL_U = 2'b11
    } src_sel_e;

    typedef enum logic {
        DIV_GATED = 1'b0,
        DIV_RUN   = 1'b1
    } div_state_e;

endpackage

// File: rtl/refclk_ctrl_reg.sv
module refclk_ctrl_reg
    import refclk_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] rdata_o,
    output src_sel_e          sel_o,
    output logic [SDIV_W-1:0] sdiv_o,
    output logic [N_W-1:0]    n_o,
    output logic [ENG_W-1:0]  eng_n_o
);

    logic [CTRL_W-1:0] word_q;
    logic              hit;

    assign hit = (addr_i == OFFSET);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_i && hit) begin
            word_q <= wdata_i & CTRL_KEEP;
        end
    end

    always_comb begin
        rdata_o = hit ? word_q : '0;
        sel_o   = src_sel_e'(word_q[SEL_LSB +: SEL_W]);
        sdiv_o  = word_q[SDIV_LSB +: SDIV_W];
        n_o     = word_q[N_LSB +: N_W];
        eng_n_o = word_q[ENG_LSB +: ENG_W];
    end

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && hit) |=> $stable(word_q)); // R5

    AST_WORD_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit) |=> (word_q == ($past(wdata_i) & CTRL_KEEP))); // R5

endmodule

// File: rtl/refclk_prescaler.sv
module refclk_prescaler #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         active_i,
    input  logic         clear_i,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o
);

    logic [W-1:0] pcnt_q;
    logic         wrap;

    assign wrap   = (pcnt_q >= ratio_i);
    assign tick_o = active_i && tick_i && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!active_i || clear_i) begin
            pcnt_q <= '0;
        end else if (tick_i) begin
            pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
        end
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (pcnt_q == '0)); // R3

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (pcnt_q <= ratio_i)); // R3

endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
    import refclk_pkg::*;
#(
    parameter int N_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [N_W-1:0] n_next_i,
    input  logic           gate_next_i,
    output logic           load_o,
    output logic           pulse_o,
    output logic           level_o
);

    localparam int HALF_W = N_W + 1;

    div_state_e        state_q, state_d;
    logic [N_W-1:0]    cnt_q, cnt_d, act_n_q;
    logic              pulse_q, period_done, load;
    logic              last;
    logic [HALF_W-1:0] half;

    assign last = (cnt_q == act_n_q);
    assign half = HALF_W'(({1'b0, act_n_q} + HALF_W'(2)) >> 1);

    // Next-state and changeover decisions
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        load        = 1'b0;
        period_done = 1'b0;
        unique case (state_q)
            DIV_GATED: begin
                load    = 1'b1;
                cnt_d   = '0;
                state_d = gate_next_i ? DIV_GATED : DIV_RUN;
            end
            DIV_RUN: begin
                if (tick_i) begin
                    if (last) begin
                        load        = 1'b1;
                        period_done = 1'b1;
                        cnt_d       = '0;
                        state_d     = gate_next_i ? DIV_GATED : DIV_RUN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = DIV_GATED;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_RUN;
            cnt_q   <= '0;
            act_n_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pulse_q <= period_done;
            if (load) begin
                act_n_q <= n_next_i;
            end
        end
    end

    // Outputs
    always_comb begin
        load_o  = load;
        pulse_o = pulse_q;
        level_o = (state_q == DIV_RUN) && ({1'b0, cnt_q} < half);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_n_q); // R1

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> $stable(act_n_q)); // R7

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (cnt_q == '0)); // R7

    AST_GATED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_GATED) |=> !pulse_o); // R4

endmodule

// File: rtl/refclk_divider_top.sv
module refclk_divider_top
    import refclk_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              xtal_tick,
    input  logic              plla_tick,
    input  logic              pllu_tick,
    input  logic              eng_src_tick,
    output logic              ref_pulse,
    output logic              ref_clk,
    output logic              eng_pulse,
    output logic              eng_clk
);

    src_sel_e          cfg_sel, act_sel_q;
    logic [SDIV_W-1:0] cfg_sdiv, act_sdiv_q;
    logic [N_W-1:0]    cfg_n;
    logic [ENG_W-1:0]  cfg_eng_n;
    logic              pll_active, pll_raw, pre_tick, main_tick;
    logic              main_load, eng_load;

    refclk_ctrl_reg #(
        .ADDR_W (ADDR_W),
        .OFFSET (CTRL_OFFSET)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .sel_o   (cfg_sel),
        .sdiv_o  (cfg_sdiv),
        .n_o     (cfg_n),
        .eng_n_o (cfg_eng_n)
    );

    // Active source settings, reloaded only at a main period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q  <= SRC_XTAL;
            act_sdiv_q <= '0;
        end else if (main_load) begin
            act_sel_q  <= cfg_sel;
            act_sdiv_q <= cfg_sdiv;
        end
    end

    assign pll_active = (act_sel_q == SRC_PLL_A) || (act_sel_q == SRC_PLL_U);
    assign pll_raw    = (act_sel_q == SRC_PLL_A) ? plla_tick : pllu_tick;

    refclk_prescaler #(
        .W (SDIV_W)
    ) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (pll_raw),
        .active_i (pll_active),
        .clear_i  (main_load),
        .ratio_i  (act_sdiv_q),
        .tick_o   (pre_tick)
    );

    always_comb begin
        unique case (act_sel_q)
            SRC_XTAL:  main_tick = xtal_tick;
            SRC_OFF:   main_tick = 1'b0;
            SRC_PLL_A: main_tick = pre_tick;
            SRC_PLL_U: main_tick = pre_tick;
            default:   main_tick = 1'b0;
        endcase
    end

    refclk_divider #(
        .N_W (N_W)
    ) i_main_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (main_tick),
        .n_next_i    (cfg_n),
        .gate_next_i (cfg_sel == SRC_OFF),
        .load_o      (main_load),
        .pulse_o     (ref_pulse),
        .level_o     (ref_clk)
    );

    refclk_divider #(
        .N_W (ENG_W)
    ) i_eng_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (eng_src_tick),
        .n_next_i    (cfg_eng_n),
        .gate_next_i (1'b0),
        .load_o      (eng_load),
        .pulse_o     (eng_pulse),
        .level_o     (eng_clk)
    );

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_sel_q == SRC_OFF) && $past(act_sel_q == SRC_OFF)) |-> (!ref_pulse && !ref_clk)); // R4

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !main_load |=> ($stable(act_sel_q) && $stable(act_sdiv_q))); // R7

    AST_ENG_PULSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pulse |-> $past(eng_load)); // R10

endmodule

// File: tb/test_refclk_divider_top.sv
`timescale 1ns/1ps
module test_refclk_divider_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h044;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xtal_tick = 1'b0, plla_tick = 1'b0, pllu_tick = 1'b0, eng_src_tick = 1'b0;
    logic        ref_pulse, ref_clk, eng_pulse, eng_clk;

    int checks = 0;
    int fails  = 0;
    int tcyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcyc <= tcyc + 1;

    refclk_divider_top i_refclk_divider_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .xtal_tick    (xtal_tick),
        .plla_tick    (plla_tick),
        .pllu_tick    (pllu_tick),
        .eng_src_tick (eng_src_tick),
        .ref_pulse    (ref_pulse),
        .ref_clk      (ref_clk),
        .eng_pulse    (eng_pulse),
        .eng_clk      (eng_clk)
    );

    // Source patterns: crystal every 2nd cycle, PLL A every cycle,
    // PLL U every 3rd cycle, engine source every cycle
    initial begin
        forever begin
            @(negedge clk);
            xtal_tick    = (tcyc % 2) == 0;
            plla_tick    = 1'b1;
            pllu_tick    = (tcyc % 3) == 0;
            eng_src_tick = 1'b1;
        end
    end

    // sel, sdiv, n, m, expected main period in cycles
    localparam logic [33:0] VEC [0:7] = '{
        {2'd0, 3'd0, 8'd0,   8'd0,   13'd2},
        {2'd0, 3'd5, 8'd3,   8'd4,   13'd8},
        {2'd2, 3'd0, 8'd4,   8'd1,   13'd5},
        {2'd2, 3'd2, 8'd1,   8'd7,   13'd6},
        {2'd3, 3'd1, 8'd2,   8'd0,   13'd18},
        {2'd3, 3'd0, 8'd0,   8'd2,   13'd3},
        {2'd2, 3'd7, 8'd9,   8'd255, 13'd80},
        {2'd0, 3'd0, 8'd255, 8'd3,   13'd512}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 12'h044;
    endtask

    task automatic read_word(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 12'h044;
    endtask

    function automatic logic sel_pulse(input bit eng);
        return eng ? eng_pulse : ref_pulse;
    endfunction

    task automatic wait_pulse(input bit eng);
        @(negedge clk);
        while (!sel_pulse(eng)) @(negedge clk);
    endtask

    task automatic measure(input bit eng, output int per, output bit hi_after);
        int t0;
        wait_pulse(eng);
        t0 = tcyc;
        @(negedge clk);
        hi_after = sel_pulse(eng);
        if (!hi_after) begin
            while (!sel_pulse(eng)) @(negedge clk);
        end
        per = tcyc - t0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          per, t0, t1, t2, high;
        bit          hi;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        read_word(12'h044, rd);
        check(rd == 32'h0, "R6 reset word", rd, 0);
        measure(1'b0, per, hi);
        check(per == 2, "R6 reset divide by 1 on crystal", per, 2);

        // R5: masking, reserved bits, other offsets
        write_word(12'h044, 32'hFFFF_FFFF);
        read_word(12'h044, rd);
        check(rd == 32'hFF1F_FF00, "R5 reserved bits read zero", rd, 32'hFF1F_FF00);
        write_word(12'h048, 32'h1234_5678);
        read_word(12'h044, rd);
        check(rd == 32'hFF1F_FF00, "R5 write elsewhere ignored", rd, 32'hFF1F_FF00);
        read_word(12'h048, rd);
        check(rd == 32'h0, "R5 other offset reads zero", rd, 0);

        // R1 R2 R3 R8 R10: vector table
        for (int i = 0; i < 8; i++) begin
            logic [1:0] vs;
            logic [2:0] vd;
            logic [7:0] vn, vm;
            int         ve;
            vs = VEC[i][33:32];
            vd = VEC[i][31:29];
            vn = VEC[i][28:21];
            vm = VEC[i][20:13];
            ve = int'(VEC[i][12:0]);
            write_word(12'h044, {vn, 3'b000, vs, vd, vm, 8'h00});
            wait_pulse(1'b0);
            wait_pulse(1'b0);
            measure(1'b0, per, hi);
            check(per == ve, "R1 R2 R3 main period", per, ve);
            if (ve > 1) check(!hi, "R10 main pulse width", int'(hi), 0);
            wait_pulse(1'b1);
            wait_pulse(1'b1);
            measure(1'b1, per, hi);
            check(per == int'(vm) + 1, "R8 engine period", per, int'(vm) + 1);
            if (vm > 0) check(!hi, "R10 engine pulse width", int'(hi), 0);
        end

        // R4: off code silences the output
        write_word(12'h044, {8'd3, 3'b000, 2'b01, 3'd0, 8'd0, 8'h00});
        wait_pulse(1'b0);
        @(negedge clk);
        high = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (ref_pulse || ref_clk) high++;
        end
        check(high == 0, "R4 off code outputs low", high, 0);
        write_word(12'h044, {8'd1, 3'b000, 2'b00, 3'd0, 8'd0, 8'h00});
        measure(1'b0, per, hi);
        check(per == 4, "R4 restart after off code", per, 4);

        // R7: mid-period change keeps the old period whole
        write_word(12'h044, {8'd9, 3'b000, 2'b00, 3'd0, 8'd0, 8'h00});
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        t0 = tcyc;
        repeat (5) @(negedge clk);
        write_word(12'h044, {8'd0, 3'b000, 2'b00, 3'd0, 8'd0, 8'h00});
        wait_pulse(1'b0);
        t1 = tcyc;
        wait_pulse(1'b0);
        t2 = tcyc;
        check((t1 - t0) == 20, "R7 old period completes", t1 - t0, 20);
        check((t2 - t1) == 2, "R7 new ratio after boundary", t2 - t1, 2);

        // R9: duty of the level output on PLL A (one tick per cycle)
        write_word(12'h044, {8'd4, 3'b000, 2'b10, 3'd0, 8'd0, 8'h00});
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        high = ref_clk ? 1 : 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ref_clk) high++;
        end
        check(high == 3, "R9 level high for N=4", high, 3);
        write_word(12'h044, {8'd3, 3'b000, 2'b10, 3'd0, 8'd0, 8'h00});
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        high = ref_clk ? 1 : 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (ref_clk) high++;
        end
        check(high == 2, "R9 level high for N=3", high, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule